// File: doc/BRIEF.md
# Page Table Walker with Fault Detection

This block is the control path of a memory management unit. A processor-side requester hands it one virtual address together with an access kind: read, write or execute. The block first looks in a small, fully associative cache of recent translations. On a miss it reads one page table entry through a simple request/response memory port. It then either refills the cache and returns a physical address, or reports a fault.

Every access is checked against the entry's read, write and execute bits, whether the translation came from the cache or from a walk. A disallowed access is reported as a protection fault. An entry whose valid bit is clear is reported as a not-present fault. A fault stays raised until the requester acknowledges it. Software may then repair the table and issue the same access again.

The page table base address is an input. It is captured with each request, so a context switch only has to change that input between requests. The block handles one request at a time.

Top module: `pgwalk_mmu`

## Requirements
- R1: While reset is low, and after it is released with no request, `done_valid`, `fault_valid` and `mem_req_valid` are all 0.
- R2: An access that hits in the translation cache and is permitted issues no memory read. `done_valid` is high for exactly one cycle, two clock edges after the edge that accepted the request.
- R3: A cache miss issues exactly one memory read, a one-cycle `mem_req_valid` pulse. Its address is `pt_base + 2 * vpn`, where vpn is `req_vaddr[13:6]`.
- R4: The 10-bit entry is decoded as follows: bit 0 is valid, bits [6:1] are the physical page number, bit 7 allows read, bit 8 allows write and bit 9 allows execute.
- R5: A permitted access completes with `done_paddr = {ppn, req_vaddr[5:0]}` (12 bits). A valid, permitted entry fetched by a walk is written into the cache, so the next access to that page hits.
- R6: A fetched entry with bit 0 clear gives `fault_cause = 0` (not present) and no `done_valid`. Such an entry is not cached.
- R7: The access kind `req_type` is coded 0 read, 1 write, 2 execute and 3 reserved, and the reserved code is never permitted. A denied access gives `fault_cause = 1` (protection), on a cache hit and on a walk alike.
- R8: `fault_valid` and `fault_cause` hold steady until `fault_ack` is sampled high. `fault_valid` is low from the next cycle on.
- R9: A faulting translation leaves no cache entry for that page. A protection fault on a hit drops the cached entry. A retry after software has fixed the table therefore walks again and completes.
- R10: A `req_valid` pulse while a request is in progress is ignored. It causes no second result and no extra memory read.
- R11: The cache refills the lowest-numbered free slot. When the cache is full it overwrites slots in round-robin order, starting at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe, accepted when idle |
| req_vaddr | input | 14 | Virtual address (8-bit page number, 6-bit offset) |
| req_type | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| pt_base | input | 16 | Base address of the current page table |
| mem_req_valid | output | 1 | One-cycle read request for a page table entry |
| mem_req_addr | output | 16 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 10 | Page table entry |
| done_valid | output | 1 | One-cycle completion strobe |
| done_paddr | output | 12 | Physical address, valid with done_valid |
| fault_valid | output | 1 | Fault raised, held until acknowledged |
| fault_cause | output | 1 | 0 not present, 1 protection |
| fault_ack | input | 1 | Requester acknowledges the fault |

## Verification
A vector table drives a range of access patterns. It covers first touches of a page, which tell a walk from a hit by the count of memory reads, and repeat touches, which show that the refill took effect and that completion comes at the fast latency. It also covers write and execute attempts against read-only and non-writable pages, which separate the protection check on the hit path from the one on the walk path, and touches of an absent page, which separate the two fault causes. Directed sequences then cover:
- a retry after the table has been repaired;
- a request that arrives while a walk is in progress;
- a five-page pattern that overfills the four-entry cache and shows which slot the round-robin pointer evicts.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WALK_REQ,
    ST_WALK_WAIT,
    ST_REFILL,
    ST_DONE,
    ST_FAULT
  } walk_state_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_t;

  localparam int PERM_W = 3;  // {exec, write, read}

  localparam logic CAUSE_ABSENT = 1'b0;
  localparam logic CAUSE_PROT   = 1'b1;

endpackage

// File: rtl/pgwalk_perm_check.sv
module pgwalk_perm_check
  import pgwalk_pkg::*;
(
  input  logic [1:0]        acc,
  input  logic [PERM_W-1:0] perm,   // [0] read, [1] write, [2] exec
  output logic              allow
);

  always_comb begin
    case (acc_kind_t'(acc))
      ACC_READ:  allow = perm[0];
      ACC_WRITE: allow = perm[1];
      ACC_EXEC:  allow = perm[2];
      default:   allow = 1'b0;
    endcase
  end

endmodule

// File: rtl/pgwalk_xlat_cache.sv
module pgwalk_xlat_cache
  import pgwalk_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 8,
  parameter int PPN_W   = 6,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  // lookup
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  // refill
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [PERM_W-1:0] wr_perm,
  // drop one entry
  input  logic              drop_en,
  input  logic [IDX_W-1:0]  drop_idx
);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   tag_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   rr_q;
  logic [IDX_W-1:0]   free_idx;
  logic               any_free;
  logic [IDX_W-1:0]   victim;

  // lowest matching slot
  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit = 1'b1;
        lk_idx = IDX_W'(i);
      end
    end
  end

  assign lk_ppn  = ppn_q[lk_idx];
  assign lk_perm = perm_q[lk_idx];

  // lowest free slot
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim = any_free ? free_idx : rr_q;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      logic sel_wr;
      assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
      assign sel_wr   = wr_en && (victim == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          valid_q[g] <= 1'b0;
        end else if (sel_wr) begin
          valid_q[g] <= 1'b1;
        end else if (drop_en && (drop_idx == IDX_W'(g))) begin
          valid_q[g] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (sel_wr) begin
          tag_q[g]  <= wr_vpn;
          ppn_q[g]  <= wr_ppn;
          perm_q[g] <= wr_perm;
        end
      end
    end
  endgenerate

  // round-robin pointer advances only on replacement of a live slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (wr_en && !any_free) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/pgwalk_mmu.sv
module pgwalk_mmu
  import pgwalk_pkg::*;
#(
  parameter int VPN_W         = 8,
  parameter int OFF_W         = 6,
  parameter int PPN_W         = 6,
  parameter int MEM_AW        = 16,
  parameter int PTE_BYTES     = 2,
  parameter int CACHE_ENTRIES = 4,
  localparam int VA_W         = VPN_W + OFF_W,
  localparam int PA_W         = PPN_W + OFF_W,
  localparam int PTE_W        = 1 + PPN_W + PERM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_type,
  input  logic [MEM_AW-1:0] pt_base,
  output logic              mem_req_valid,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              done_valid,
  output logic [PA_W-1:0]   done_paddr,
  output logic              fault_valid,
  output logic              fault_cause,
  input  logic              fault_ack
);

  localparam int PTE_SHIFT = $clog2(PTE_BYTES);
  localparam int IDX_W     = (CACHE_ENTRIES > 1) ? $clog2(CACHE_ENTRIES) : 1;
  localparam int PPN_LSB   = 1;
  localparam int PERM_LSB  = 1 + PPN_W;

  walk_state_t       state_q, state_d;
  logic [VA_W-1:0]   vaddr_q;
  logic [1:0]        acc_q;
  logic [MEM_AW-1:0] base_q;
  logic [PTE_W-1:0]  pte_q;
  logic [PPN_W-1:0]  ppn_q, ppn_d;
  logic              cause_q, cause_d;
  logic              ld_req, ld_pte, ld_ppn, ld_cause;
  logic              walker_busy;

  logic [VPN_W-1:0]  cur_vpn;
  logic              pte_present;
  logic [PPN_W-1:0]  pte_ppn;
  logic [PERM_W-1:0] pte_perm;

  logic              lk_hit;
  logic [IDX_W-1:0]  lk_idx;
  logic [PPN_W-1:0]  lk_ppn;
  logic [PERM_W-1:0] lk_perm;
  logic              cache_wr, cache_drop;
  logic [PERM_W-1:0] chk_perm;
  logic              allow;

  assign cur_vpn     = vaddr_q[VA_W-1:OFF_W];
  assign pte_present = pte_q[0];
  assign pte_ppn     = pte_q[PPN_LSB +: PPN_W];
  assign pte_perm    = pte_q[PERM_LSB +: PERM_W];
  assign walker_busy = (state_q != ST_IDLE);

  pgwalk_xlat_cache #(
    .ENTRIES (CACHE_ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (PPN_W)
  ) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_vpn   (cur_vpn),
    .lk_hit   (lk_hit),
    .lk_idx   (lk_idx),
    .lk_ppn   (lk_ppn),
    .lk_perm  (lk_perm),
    .wr_en    (cache_wr),
    .wr_vpn   (cur_vpn),
    .wr_ppn   (pte_ppn),
    .wr_perm  (pte_perm),
    .drop_en  (cache_drop),
    .drop_idx (lk_idx)
  );

  // one permission checker shared by the hit and walk paths
  assign chk_perm = (state_q == ST_REFILL) ? pte_perm : lk_perm;

  pgwalk_perm_check u_perm (
    .acc   (acc_q),
    .perm  (chk_perm),
    .allow (allow)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    ld_req     = 1'b0;
    ld_pte     = 1'b0;
    ld_ppn     = 1'b0;
    ld_cause   = 1'b0;
    ppn_d      = lk_ppn;
    cause_d    = CAUSE_ABSENT;
    cache_wr   = 1'b0;
    cache_drop = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req  = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (lk_hit) begin
          if (allow) begin
            ld_ppn  = 1'b1;
            state_d = ST_DONE;
          end else begin
            cache_drop = 1'b1;
            ld_cause   = 1'b1;
            cause_d    = CAUSE_PROT;
            state_d    = ST_FAULT;
          end
        end else begin
          state_d = ST_WALK_REQ;
        end
      end
      ST_WALK_REQ: state_d = ST_WALK_WAIT;
      ST_WALK_WAIT: begin
        if (mem_rsp_valid) begin
          ld_pte  = 1'b1;
          state_d = ST_REFILL;
        end
      end
      ST_REFILL: begin
        if (!pte_present) begin
          ld_cause = 1'b1;
          cause_d  = CAUSE_ABSENT;
          state_d  = ST_FAULT;
        end else if (!allow) begin
          ld_cause = 1'b1;
          cause_d  = CAUSE_PROT;
          state_d  = ST_FAULT;
        end else begin
          cache_wr = 1'b1;
          ld_ppn   = 1'b1;
          ppn_d    = pte_ppn;
          state_d  = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      ST_FAULT: begin
        if (fault_ack) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vaddr_q <= '0;
      acc_q   <= '0;
      base_q  <= '0;
      pte_q   <= '0;
      ppn_q   <= '0;
      cause_q <= CAUSE_ABSENT;
    end else begin
      state_q <= state_d;
      if (ld_req) begin
        vaddr_q <= req_vaddr;
        acc_q   <= req_type;
        base_q  <= pt_base;
      end
      if (ld_pte)   pte_q   <= mem_rsp_data;
      if (ld_ppn)   ppn_q   <= ppn_d;
      if (ld_cause) cause_q <= cause_d;
    end
  end

  assign mem_req_valid = (state_q == ST_WALK_REQ);
  assign mem_req_addr  = base_q + (MEM_AW'(cur_vpn) << PTE_SHIFT);
  assign done_valid    = (state_q == ST_DONE);
  assign done_paddr    = {ppn_q, vaddr_q[OFF_W-1:0]};
  assign fault_valid   = (state_q == ST_FAULT);
  assign fault_cause   = cause_q;

endmodule

// File: rtl/pgwalk_mmu_chk.sv
module pgwalk_mmu_chk #(
  parameter int VA_W = 14
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req_valid,
  input logic            done_valid,
  input logic            fault_valid,
  input logic            fault_cause,
  input logic            fault_ack,
  input logic            walker_busy,
  input logic [VA_W-1:0] vaddr_q
);

  // R3: a walk reads memory with a single one-cycle request
  p_one_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R2: completion is a single-cycle strobe
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R8: an unacknowledged fault stays raised with the same cause
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && !fault_ack) |=> (fault_valid && $stable(fault_cause)));

  // R8: acknowledgement releases the fault
  p_fault_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_ack) |=> !fault_valid);

  // R10: the captured request does not change while one is in progress
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    walker_busy |=> $stable(vaddr_q));

endmodule

bind pgwalk_mmu pgwalk_mmu_chk #(.VA_W(VA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .done_valid    (done_valid),
  .fault_valid   (fault_valid),
  .fault_cause   (fault_cause),
  .fault_ack     (fault_ack),
  .walker_busy   (walker_busy),
  .vaddr_q       (vaddr_q)
);

// File: tb/sim_pgwalk_mmu.sv
`timescale 1ns/1ps
module sim_pgwalk_mmu;

  localparam logic [15:0] BASE = 16'h1000;
  localparam int NVEC = 10;
  // {vaddr14, type2, is_fault1, cause1, paddr12, reads2}
  localparam logic [31:0] VEC [NVEC] = '{
    {14'h03D4, 2'd0, 1'b0, 1'b0, 12'h354, 2'd1},
    {14'h03FF, 2'd0, 1'b0, 1'b0, 12'h37F, 2'd0},
    {14'h03C0, 2'd1, 1'b1, 1'b1, 12'h000, 2'd0},
    {14'h03C5, 2'd0, 1'b0, 1'b0, 12'h345, 2'd1},
    {14'h00A0, 2'd1, 1'b0, 1'b0, 12'hCE0, 2'd1},
    {14'h0B8F, 2'd2, 1'b0, 1'b0, 12'h44F, 2'd1},
    {14'h0B8F, 2'd1, 1'b1, 1'b1, 12'h000, 2'd0},
    {14'h0020, 2'd0, 1'b1, 1'b0, 12'h000, 2'd1},
    {14'h00A0, 2'd3, 1'b1, 1'b1, 12'h000, 2'd0},
    {14'h00A1, 2'd1, 1'b0, 1'b0, 12'hCE1, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [13:0] req_vaddr;
  logic [1:0]  req_type;
  logic [15:0] pt_base;
  logic        mem_req_valid;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [9:0]  mem_rsp_data;
  logic        done_valid;
  logic [11:0] done_paddr;
  logic        fault_valid;
  logic        fault_cause;
  logic        fault_ack;

  logic [9:0]  pt [256];
  logic [7:0]  cur_vpn;
  int          reads;
  int          addr_bad;
  int          checks;
  int          fails;

  always #4 clk = ~clk;

  pgwalk_mmu u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_type(req_type), .pt_base(pt_base), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done_valid(done_valid), .done_paddr(done_paddr),
    .fault_valid(fault_valid), .fault_cause(fault_cause), .fault_ack(fault_ack)
  );

  // memory responder: two-cycle latency, checks the entry address (R3)
  initial begin
    reads = 0;
    addr_bad = 0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        reads = reads + 1;
        if (mem_req_addr != BASE + {7'd0, cur_vpn, 1'b0}) addr_bad = addr_bad + 1;
        repeat (2) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = pt[cur_vpn];
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  initial begin
    #(8 * 100000);
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request; returns outcome, observed reads and latency
  task automatic xlat(input logic [13:0] va, input logic [1:0] ty,
                      output bit is_fault, output bit cause,
                      output logic [11:0] pa, output int nrd, output int lat);
    int r0;
    int b0;
    r0 = reads;
    b0 = addr_bad;
    @(negedge clk);
    cur_vpn = va[13:6];
    req_vaddr = va;
    req_type = ty;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done_valid && !fault_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    is_fault = fault_valid;
    cause = fault_cause;
    pa = done_paddr;
    if (fault_valid) begin
      repeat (2) @(negedge clk);
      check(fault_valid && fault_cause == cause, "R8 hold", int'(fault_cause), int'(cause));
      fault_ack = 1'b1;
      @(negedge clk);
      fault_ack = 1'b0;
      check(!fault_valid, "R8 release", int'(fault_valid), 0);
    end else begin
      @(negedge clk);
      check(!done_valid, "R2 pulse", int'(done_valid), 0);
    end
    nrd = reads - r0;
    check(addr_bad == b0, "R3 entry address", addr_bad - b0, 0);
  endtask

  task automatic expect_ok(input logic [13:0] va, input logic [1:0] ty,
                           input logic [11:0] epa, input int erd);
    bit f; bit c; logic [11:0] pa; int n; int lat;
    xlat(va, ty, f, c, pa, n, lat);
    check(!f, "R5 completes", int'(f), 0);
    check(pa == epa, "R5 paddr", int'(pa), int'(epa));
    check(n == erd, "R3 read count", n, erd);
    if (erd == 0) check(lat == 2, "R2 hit latency", lat, 2);
  endtask

  task automatic expect_fault(input logic [13:0] va, input logic [1:0] ty,
                              input bit ecause, input int erd);
    bit f; bit c; logic [11:0] pa; int n; int lat;
    xlat(va, ty, f, c, pa, n, lat);
    check(f, ecause ? "R7 fault raised" : "R6 fault raised", int'(f), 1);
    check(c == ecause, ecause ? "R7 cause" : "R6 cause", int'(c), int'(ecause));
    check(n == erd, "R3 read count", n, erd);
  endtask

  initial begin
    checks = 0;
    fails = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    req_type = '0;
    pt_base = BASE;
    fault_ack = 1'b0;
    cur_vpn = '0;
    for (int i = 0; i < 256; i++) pt[i] = '0;
    // R4 layout: [0] valid, [6:1] ppn, [7] R, [8] W, [9] X
    pt[8'h0F] = 10'h09B;  // ppn 0D, R
    pt[8'h02] = 10'h1E7;  // ppn 33, RW
    pt[8'h2E] = 10'h2A3;  // ppn 11, RX

    repeat (3) @(negedge clk);
    check(!done_valid && !fault_valid && !mem_req_valid, "R1 in reset",
          {done_valid, fault_valid, mem_req_valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!done_valid && !fault_valid && !mem_req_valid, "R1 after reset",
          {done_valid, fault_valid, mem_req_valid}, 0);

    // table walk: R2 R3 R5 R6 R7 R9
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][15])
        expect_fault(VEC[v][31:18], VEC[v][17:16], VEC[v][14], int'(VEC[v][1:0]));
      else
        expect_ok(VEC[v][31:18], VEC[v][17:16], VEC[v][13:2], int'(VEC[v][1:0]));
    end

    // R9: repair an absent entry, retry walks then hits
    pt[8'h00] = 10'h08B;  // ppn 05, R
    expect_ok(14'h0020, 2'd0, 12'h160, 1);
    expect_ok(14'h0020, 2'd0, 12'h160, 0);

    // R10: request during a walk is ignored
    begin
      int r0;
      int seen;
      r0 = reads;
      @(negedge clk);
      cur_vpn = 8'h2E;
      req_vaddr = 14'h0B8F;
      req_type = 2'd2;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      req_vaddr = 14'h03D4;
      req_type = 2'd0;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      seen = 0;
      while (!done_valid && !fault_valid && seen < 60) begin
        @(negedge clk);
        seen++;
      end
      check(done_valid && done_paddr == 12'h44F, "R10 first request result",
            int'(done_paddr), 12'h44F);
      seen = 0;
      repeat (10) begin
        @(negedge clk);
        if (done_valid || fault_valid) seen++;
      end
      check(seen == 1 - 1, "R10 no second result", seen, 0);
      check(reads - r0 == 1, "R10 read count", reads - r0, 1);
    end

    // R11: cache now full {0F,02,00,2E}; round-robin from slot 0
    pt[8'h10] = 10'h1D5;  // ppn 2A, RW
    expect_ok(14'h0403, 2'd0, 12'hA83, 1);  // evicts 0F
    expect_ok(14'h03D4, 2'd0, 12'h354, 1);  // R11 0F gone, evicts 02
    expect_ok(14'h0B8F, 2'd2, 12'h44F, 0);  // R11 2E kept
    expect_ok(14'h00A0, 2'd1, 12'hCE0, 1);  // R11 02 gone, evicts 00
    expect_ok(14'h0020, 2'd0, 12'h160, 1);  // R11 00 gone

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule